// File: doc/BRIEF.md
# Timed Countdown-and-Promote Instruction Scheduler

This block schedules instructions without tag-broadcast wakeup and without a select arbiter. Each instruction arrives on a valid/ready decode port together with a predicted delay, the number of cycles until its source operands should be available. It first waits in a countdown pool. Once its remaining delay has fallen to half the scheduling window, it moves into a small array of columns. The array shifts every entry one column toward column 0 on each clock. Whatever sits in column 0 is offered for issue on that cycle, and the array provides one issue lane per row.

A register scoreboard is checked at the issue point. If both sources of an instruction in column 0 are marked ready, it issues. Otherwise it is sent back to the countdown pool with a short fixed delay and tries again. A destination register is marked not-ready when its producer is accepted. It becomes ready again a per-instruction latency after that producer issues, which stands in for writeback.

The issue side has no back-pressure, because issue time is fixed by position and the lanes cannot stall. Back-pressure exists only on the decode side. `in_ready` drops when the in-flight limit is reached or when a replay is being written into the pool. An instruction is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_valid` and the payload must stay stable until that edge.

Top module: `tsched_top`

## Requirements
- R1: After reset, `in_ready` is 1 and no `iss_valid` bit is set.
- R2: An instruction accepted at clock edge A with delay d (4-bit unsigned, 0 to 15) and with ready sources, meeting no collision, is on an issue lane in the cycle after edge A+d+1. If d exceeds half the window (NCOL/2 = 4), it first counts down in the pool until its count equals 4, and then enters column 4.
- R3: Every cycle the column array shifts one column toward column 0. All occupied rows of column 0 are presented on the same cycle, each on its own lane (`iss_valid` bit r, with the tag in bits r*6 +: 6 of `iss_tag`).
- R4: At most one instruction moves from the pool into the array per cycle, and the lowest pool slot goes first. If the move would land in a column whose rows will all be occupied after the shift, the instruction stays in the pool with its count unchanged, so its issue slips by one cycle per lost attempt.
- R5: An instruction in column 0 with a source that is not ready is not issued. It re-enters the pool with delay 2 and next reaches column 0 three cycles after the edge that removed it.
- R6: `in_ready` is 0 during any cycle in which a replay is being written into the pool.
- R7: `in_ready` is 0 while CD_DEPTH (default 8) instructions are in the pool and the array together.
- R8: Accepting an instruction clears the ready bit of its destination. The bit is set again L cycles after the producer's issue cycle, where L is its 3-bit latency (0 treated as 1). With L = 1, a dependent instruction can issue on the very next cycle.
- R9: Every accepted instruction leaves on an issue lane exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | Scheduler can accept this cycle |
| in_tag | input | 6 | Instruction identifier |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| in_dst | input | 5 | Destination register |
| in_dly | input | 4 | Predicted cycles until operands are ready |
| in_lat | input | 3 | Cycles from issue until the result is ready |
| iss_valid | output | 4 | One bit per issue lane |
| iss_tag | output | 24 | Tag on each lane, 6 bits per lane |
| iss_dst | output | 20 | Destination on each lane, 5 bits per lane |

## Verification
The bench walks a table of delays on both sides of the half-window boundary. An off-by-one in the countdown exit point or in the column entry point shows there as a one-cycle shift in issue time. It builds a column collision by steering five instructions onto one issue cycle with four rows. A design that overwrote a row would lose one tag, and one that did not hold the loser would issue it early or never. It stages a dependent instruction behind a three-cycle producer, which exposes a missing replay, a wrong replay delay, or decode accepted while a replay was being written. It also fills the in-flight limit, where a design that leaked back-pressure would accept a ninth instruction early.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  localparam int TAG_W = 6;
  localparam int REG_W = 5;
  localparam int DLY_W = 4;
  localparam int LAT_W = 3;
  localparam int NREG  = 1 << REG_W;
  localparam logic [DLY_W-1:0] REPLAY_DLY = DLY_W'(2);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
    logic [LAT_W-1:0] lat;
  } uop_t;
endpackage

// File: rtl/tsched_countdown.sv
module tsched_countdown
  import tsched_pkg::*;
#(
  parameter int CD_DEPTH = 8,
  parameter int NROW     = 4,
  parameter int HALF     = 4,
  parameter int QCOLS    = HALF + 1,
  parameter int OCC_W    = $clog2(CD_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_fire,
  input  uop_t             dec_uop,
  input  logic [DLY_W-1:0] dec_dly,
  input  logic [NROW-1:0]  rep_req,
  input  uop_t             rep_uop [NROW],
  input  logic [QCOLS-1:0] col_full,
  output logic             ins_valid,
  output logic [DLY_W-1:0] ins_col,
  output uop_t             ins_uop,
  output logic [OCC_W-1:0] occ
);
  localparam logic [DLY_W-1:0] HALF_C = DLY_W'(HALF);

  logic [CD_DEPTH-1:0] cd_v;
  logic [DLY_W-1:0]    cd_cnt [CD_DEPTH];
  uop_t                cd_u   [CD_DEPTH];

  int                  rep_list [NROW];
  int                  nrep;
  int                  free_rank;
  logic [CD_DEPTH-1:0] ld_rep, ld_dec, gnt;
  int                  ld_row [CD_DEPTH];

  // slot allocation: replays take the lowest free slots, decode the next one
  always_comb begin
    nrep = 0;
    for (int r = 0; r < NROW; r++) rep_list[r] = 0;
    for (int r = 0; r < NROW; r++) begin
      if (rep_req[r]) begin
        rep_list[nrep] = r;
        nrep = nrep + 1;
      end
    end
    free_rank = 0;
    for (int s = 0; s < CD_DEPTH; s++) begin
      ld_rep[s] = 1'b0;
      ld_dec[s] = 1'b0;
      ld_row[s] = 0;
      if (!cd_v[s]) begin
        if (free_rank < nrep) begin
          ld_rep[s] = 1'b1;
          ld_row[s] = rep_list[free_rank];
        end else if (free_rank == nrep && dec_fire) begin
          ld_dec[s] = 1'b1;
        end
        free_rank = free_rank + 1;
      end
    end
  end

  // one move into the column array per cycle, lowest eligible slot first
  always_comb begin
    gnt       = '0;
    ins_valid = 1'b0;
    ins_col   = '0;
    ins_uop   = cd_u[0];
    for (int s = 0; s < CD_DEPTH; s++) begin
      if (!ins_valid && cd_v[s] && cd_cnt[s] <= HALF_C) begin
        if (!col_full[int'(cd_cnt[s])]) begin
          gnt[s]    = 1'b1;
          ins_valid = 1'b1;
          ins_col   = cd_cnt[s];
          ins_uop   = cd_u[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_v <= '0;
      for (int s = 0; s < CD_DEPTH; s++) cd_cnt[s] <= '0;
    end else begin
      for (int s = 0; s < CD_DEPTH; s++) begin
        if (gnt[s]) cd_v[s] <= 1'b0;
        else if (cd_v[s] && cd_cnt[s] > HALF_C) cd_cnt[s] <= cd_cnt[s] - 1'b1;
        if (ld_rep[s]) begin
          cd_v[s]   <= 1'b1;
          cd_cnt[s] <= REPLAY_DLY;
        end else if (ld_dec[s]) begin
          cd_v[s]   <= 1'b1;
          cd_cnt[s] <= dec_dly;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < CD_DEPTH; s++) begin
      if (ld_rep[s]) cd_u[s] <= rep_uop[ld_row[s]];
      else if (ld_dec[s]) cd_u[s] <= dec_uop;
    end
  end

  assign occ = OCC_W'($countones(cd_v));

  for (genvar s = 0; s < CD_DEPTH; s++) begin : g_cd_chk
    // R2
    cd_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cd_v[s] && cd_cnt[s] > HALF_C) |=> (cd_v[s] && cd_cnt[s] == $past(cd_cnt[s]) - 1'b1));
    // R4
    cd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cd_v[s] && cd_cnt[s] <= HALF_C && !gnt[s]) |=> (cd_v[s] && $stable(cd_cnt[s])));
  end
endmodule

// File: rtl/tsched_columns.sv
module tsched_columns
  import tsched_pkg::*;
#(
  parameter int QCOLS = 5,
  parameter int NROW  = 4,
  parameter int OCC_W = $clog2(QCOLS * NROW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [DLY_W-1:0] ins_col,
  input  uop_t             ins_uop,
  output logic [QCOLS-1:0] col_full,
  output logic [NROW-1:0]  head_valid,
  output uop_t             head_uop [NROW],
  output logic [OCC_W-1:0] occ
);
  logic [NROW-1:0] v_q  [QCOLS];
  uop_t            u_q  [QCOLS][NROW];
  logic [NROW-1:0] v_sh [QCOLS];
  uop_t            u_sh [QCOLS][NROW];
  logic [NROW-1:0] v_n  [QCOLS];
  uop_t            u_n  [QCOLS][NROW];
  logic            placed;

  // promotion: column c takes what column c+1 held; the top column empties
  for (genvar c = 0; c < QCOLS; c++) begin : g_shift
    if (c < QCOLS - 1) begin : g_mid
      assign v_sh[c]     = v_q[c+1];
      assign u_sh[c]     = u_q[c+1];
      assign col_full[c] = &v_q[c+1];
    end else begin : g_top
      assign v_sh[c]     = '0;
      assign u_sh[c]     = u_q[c];
      assign col_full[c] = 1'b0;
    end
  end

  always_comb begin
    placed = 1'b0;
    for (int c = 0; c < QCOLS; c++) begin
      v_n[c] = v_sh[c];
      u_n[c] = u_sh[c];
      for (int r = 0; r < NROW; r++) begin
        if (ins_valid && !placed && c == int'(ins_col) && !v_sh[c][r]) begin
          v_n[c][r] = 1'b1;
          u_n[c][r] = ins_uop;
          placed    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < QCOLS; c++) v_q[c] <= '0;
    end else begin
      v_q <= v_n;
    end
  end

  always_ff @(posedge clk) u_q <= u_n;

  assign head_valid = v_q[0];
  assign head_uop   = u_q[0];

  always_comb begin
    occ = '0;
    for (int c = 0; c < QCOLS; c++) occ = occ + OCC_W'($countones(v_q[c]));
  end

  for (genvar c = 1; c < QCOLS; c++) begin : g_col_chk
    for (genvar r = 0; r < NROW; r++) begin : g_row_chk
      // R3
      promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[c][r] |=> v_q[c-1][r]);
    end
  end
endmodule

// File: rtl/tsched_scoreboard.sv
module tsched_scoreboard
  import tsched_pkg::*;
#(
  parameter int NROW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_fire,
  input  logic [REG_W-1:0] dec_dst,
  input  logic [NROW-1:0]  head_valid,
  input  uop_t             head_uop [NROW],
  output logic [NROW-1:0]  iss_ok,
  output logic [NROW-1:0]  rep_req
);
  logic [NREG-1:0]  rdy;
  logic [LAT_W-1:0] tmr [NREG];

  always_comb begin
    for (int r = 0; r < NROW; r++) begin
      iss_ok[r]  = head_valid[r] & rdy[head_uop[r].src_a] & rdy[head_uop[r].src_b];
      rep_req[r] = head_valid[r] & ~(rdy[head_uop[r].src_a] & rdy[head_uop[r].src_b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy <= '1;
      for (int g = 0; g < NREG; g++) tmr[g] <= '0;
    end else begin
      for (int g = 0; g < NREG; g++) begin
        if (tmr[g] == LAT_W'(1)) begin
          rdy[g] <= 1'b1;
          tmr[g] <= '0;
        end else if (tmr[g] != '0) begin
          tmr[g] <= tmr[g] - 1'b1;
        end
      end
      if (dec_fire) rdy[dec_dst] <= 1'b0;
      for (int r = 0; r < NROW; r++) begin
        if (iss_ok[r]) begin
          if (head_uop[r].lat <= LAT_W'(1)) rdy[head_uop[r].dst] <= 1'b1;
          else tmr[head_uop[r].dst] <= head_uop[r].lat - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_sb_chk
    // R8
    wb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr[g] == LAT_W'(1)) |=> (rdy[g] || $past(dec_fire && dec_dst == REG_W'(g))));
  end
endmodule

// File: rtl/tsched_top.sv
module tsched_top
  import tsched_pkg::*;
#(
  parameter int NCOL     = 8,
  parameter int NROW     = 4,
  parameter int CD_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [TAG_W-1:0]      in_tag,
  input  logic [REG_W-1:0]      in_src_a,
  input  logic [REG_W-1:0]      in_src_b,
  input  logic [REG_W-1:0]      in_dst,
  input  logic [DLY_W-1:0]      in_dly,
  input  logic [LAT_W-1:0]      in_lat,
  output logic [NROW-1:0]       iss_valid,
  output logic [NROW*TAG_W-1:0] iss_tag,
  output logic [NROW*REG_W-1:0] iss_dst
);
  localparam int HALF   = NCOL / 2;
  localparam int QCOLS  = HALF + 1;
  localparam int CD_OW  = $clog2(CD_DEPTH + 1);
  localparam int Q_OW   = $clog2(QCOLS * NROW + 1);

  uop_t             dec_uop;
  logic             dec_fire;
  logic [NROW-1:0]  rep_req, iss_ok, head_valid;
  uop_t             head_uop [NROW];
  logic [QCOLS-1:0] col_full;
  logic             ins_valid;
  logic [DLY_W-1:0] ins_col;
  uop_t             ins_uop;
  logic [CD_OW-1:0] cd_occ;
  logic [Q_OW-1:0]  q_occ;
  int               inflight;

  assign dec_uop  = '{tag: in_tag, src_a: in_src_a, src_b: in_src_b, dst: in_dst, lat: in_lat};
  assign inflight = int'(cd_occ) + int'(q_occ);
  assign in_ready = ~|rep_req && (inflight < CD_DEPTH);
  assign dec_fire = in_valid && in_ready;

  tsched_countdown #(.CD_DEPTH(CD_DEPTH), .NROW(NROW), .HALF(HALF), .QCOLS(QCOLS), .OCC_W(CD_OW))
  u_pool (
    .clk(clk), .rst_n(rst_n), .dec_fire(dec_fire), .dec_uop(dec_uop), .dec_dly(in_dly),
    .rep_req(rep_req), .rep_uop(head_uop), .col_full(col_full),
    .ins_valid(ins_valid), .ins_col(ins_col), .ins_uop(ins_uop), .occ(cd_occ)
  );

  tsched_columns #(.QCOLS(QCOLS), .NROW(NROW), .OCC_W(Q_OW)) u_cols (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_col(ins_col), .ins_uop(ins_uop),
    .col_full(col_full), .head_valid(head_valid), .head_uop(head_uop), .occ(q_occ)
  );

  tsched_scoreboard #(.NROW(NROW)) u_sb (
    .clk(clk), .rst_n(rst_n), .dec_fire(dec_fire), .dec_dst(in_dst),
    .head_valid(head_valid), .head_uop(head_uop), .iss_ok(iss_ok), .rep_req(rep_req)
  );

  assign iss_valid = iss_ok;
  for (genvar r = 0; r < NROW; r++) begin : g_lane
    assign iss_tag[r*TAG_W +: TAG_W] = head_uop[r].tag;
    assign iss_dst[r*REG_W +: REG_W] = head_uop[r].dst;
  end

  // R4
  ins_target_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (int'(ins_col) <= HALF && !col_full[ins_col]));
  // R7
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CD_DEPTH);
  // R6
  replay_no_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rep_req) |=> (int'(cd_occ) >= $countones($past(rep_req))));
endmodule

// File: tb/tsched_top_tb_top.sv
module tsched_top_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  localparam int VEC_DLY [NV] = '{0, 1, 2, 3, 4, 5, 9, 15};
  localparam int VEC_EXP [NV] = '{1, 2, 3, 4, 5, 6, 10, 16};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [5:0]  in_tag = '0;
  logic [4:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [3:0]  in_dly = '0;
  logic [2:0]  in_lat = '0;
  logic [3:0]  iss_valid;
  logic [23:0] iss_tag;
  logic [19:0] iss_dst;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int first_iss [64];
  int iss_cnt   [64];
  bit finished = 0;

  tsched_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_dly(in_dly), .in_lat(in_lat),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_dst(iss_dst)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    for (int r = 0; r < 4; r++) begin
      if (rst_n && iss_valid[r]) begin
        if (first_iss[iss_tag[r*6 +: 6]] < 0) first_iss[iss_tag[r*6 +: 6]] = cyc;
        iss_cnt[iss_tag[r*6 +: 6]]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input int tag, input int sa, input int sb, input int dst,
                      input int dly, input int lat, output int acc);
    in_valid = 1'b1;
    in_tag = 6'(tag); in_src_a = 5'(sa); in_src_b = 5'(sb); in_dst = 5'(dst);
    in_dly = 4'(dly); in_lat = 3'(lat);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    acc = cyc;
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int acc, a0, acc9;
    for (int t = 0; t < 64; t++) begin first_iss[t] = -1; iss_cnt[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(iss_valid == '0, "R1 iss_valid", int'(iss_valid), 0);

    // R2 table of delays around the half-window boundary
    for (int i = 0; i < NV; i++) begin
      send(i, 1, 2, 10, VEC_DLY[i], 1, acc);
      repeat (25) @(negedge clk);
      chk(first_iss[i] == acc + VEC_EXP[i], "R2 issue cycle", first_iss[i] - acc, VEC_EXP[i]);
      chk(iss_cnt[i] == 1, "R9 issued once", iss_cnt[i], 1);
    end

    // R3/R4 five instructions aimed at one cycle, four rows
    send(20, 1, 2, 11, 4, 1, a0);
    send(21, 1, 2, 12, 3, 1, acc);
    send(22, 1, 2, 13, 2, 1, acc);
    send(23, 1, 2, 14, 1, 1, acc);
    send(24, 1, 2, 15, 0, 1, acc);
    repeat (20) @(negedge clk);
    for (int t = 20; t < 24; t++)
      chk(first_iss[t] == a0 + 5, "R3 same-cycle lanes", first_iss[t] - a0, 5);
    chk(first_iss[24] == a0 + 6, "R4 collision slip", first_iss[24] - a0, 6);
    chk(iss_cnt[24] == 1, "R9 collision no loss", iss_cnt[24], 1);

    // R5/R6 consumer behind a 3-cycle producer
    send(30, 1, 2, 5, 0, 3, a0);
    send(31, 5, 2, 6, 0, 1, acc);
    @(negedge clk);
    chk(in_ready == 1'b0, "R6 stall on replay", int'(in_ready), 0);
    repeat (15) @(negedge clk);
    chk(first_iss[30] == a0 + 1, "R2 producer issue", first_iss[30] - a0, 1);
    chk(first_iss[31] == a0 + 6, "R5 replay reissue", first_iss[31] - a0, 6);
    chk(iss_cnt[31] == 1, "R5 single issue", iss_cnt[31], 1);

    // R8 back-to-back with latency 1
    send(32, 1, 2, 7, 0, 1, a0);
    send(33, 7, 2, 8, 0, 1, acc);
    repeat (12) @(negedge clk);
    chk(first_iss[33] == a0 + 2, "R8 back-to-back", first_iss[33] - a0, 2);
    chk(iss_cnt[33] == 1, "R8 no replay", iss_cnt[33], 1);

    // R7 in-flight limit
    send(40, 1, 2, 16, 15, 1, a0);
    for (int k = 1; k < 8; k++) send(40 + k, 1, 2, 16 + k, 15, 1, acc);
    chk(in_ready == 1'b0, "R7 full", int'(in_ready), 0);
    send(48, 1, 2, 24, 15, 1, acc9);
    chk(acc9 == a0 + 18, "R7 accept after drain", acc9 - a0, 18);
    repeat (30) @(negedge clk);
    chk(first_iss[48] == acc9 + 16, "R2 ninth issue", first_iss[48] - acc9, 16);
    for (int k = 0; k < 9; k++)
      chk(iss_cnt[40 + k] == 1, "R9 burst issued once", iss_cnt[40 + k], 1);

    finish_run();
  end
endmodule